// File: doc/BRIEF.md
# Submission Queue Fetch Controller

This block serves one circular ring of fixed-size command entries. The ring lives in a local RAM that stands in for host memory, and software fills it through a write port. Software rings a doorbell by writing a new tail slot. The controller then reads entries one at a time from its head slot toward the tail. Each valid entry goes out on a downstream command port as a one-cycle pulse, tagged with the identifier of the completion queue paired with this ring.

A control register lets software pause and resume fetching. A status register reports when the pause has taken effect. While the ring is paused, software can ask the block to cancel one pending command, named by its nexus (logical unit and task tag). The block searches the entries between head and tail and overwrites the command type of the first match with the reserved "null" value, so that entry is never issued. The search result appears in the status register. A configurable limit caps how many issued commands may be outstanding at once, and a completion input returns those credits.

Top module: `sq_fetch_ctrl`

## Requirements
- R1: Attribute register (address 0): bit 31 enables the queue. Bits 15:0 give the ring size in 32-bit words minus one, with 8 words per entry, so the entry count is (field+1)/8. Bits 23:16 carry the paired completion queue ID, which appears on `cmd_cqid` with every issued command. No entry is fetched while bit 31 is clear.
- R2: Entries are issued in slot order from head to tail, one `cmd_valid` pulse per entry, with the full entry on `cmd_entry`. The ring is empty when head equals tail.
- R3: The head slot wraps to 0 after the last entry. It can be read at address 3. The tail (doorbell) is held at address 2 and can be read back there.
- R4: An entry whose command type (bits 31:28) equals 0xF is not issued, and the head still advances past it.
- R5: Writing bit 0 of the control register (address 4) requests a stop. Status bit 0 (address 6) sets once no fetch is in progress. No command is issued while that bit is set.
- R6: Writing bit 1 of the control register while stopped clears status bit 0 and resumes fetching.
- R7: With the block stopped, writing bit 2 of the control register starts a cleanup. The block compares the nexus register (address 5, LUN<<8 | tag) with entry bits 15:0 of the pending, non-null entries from head to tail. It nullifies the first match. It then sets status bit 1 and writes status bits 7:4 with 0 if an entry was nullified or 1 if none matched. The head pointer is not moved.
- R8: A cleanup request while fetching is running is ignored. Any control command that arrives during a cleanup in progress is ignored.
- R9: Configuration bits 16:8 (address 1) hold the maximum number of outstanding commands minus one. Fetching stalls while that many are outstanding.
- R10: A `cpl` pulse returns one credit. A pulse with nothing outstanding is ignored, and the counter does not underflow.
- R11: Register reads return data one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_we | input | 1 | Entry RAM write strobe |
| mem_addr | input | 4 | Entry RAM slot |
| mem_wdata | input | 32 | Entry RAM write data |
| cpl | input | 1 | One command completed |
| cmd_valid | output | 1 | Command issue pulse |
| cmd_entry | output | 32 | Issued entry |
| cmd_cqid | output | 8 | Paired completion queue ID |

## Verification
The bench goes after the slot wrap: a head that ran past the entry count would issue stale slots and read back a wrong head. It places a null-type entry between valid ones, so an issuer that ignores the type field shows up as an extra command. It sends completions beyond the outstanding count and then checks that the limit still admits exactly the configured number; a counter that wrapped below zero would stall for good. For cleanup, it checks that the matching entry is skipped but its neighbours are issued, that a second search for the same nexus reports "not found", and that a start sent during the search, or a cleanup sent while running, leaves the status untouched.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_EVAL, ST_STOP, ST_CL_RD, ST_CL_CMP
  } eng_state_t;

  localparam logic [2:0] A_ATTR   = 3'd0;
  localparam logic [2:0] A_CFG    = 3'd1;
  localparam logic [2:0] A_TAIL   = 3'd2;
  localparam logic [2:0] A_HEAD   = 3'd3;
  localparam logic [2:0] A_CTRL   = 3'd4;
  localparam logic [2:0] A_NEXUS  = 3'd5;
  localparam logic [2:0] A_STATUS = 3'd6;

  localparam int CTRL_STOP  = 0;
  localparam int CTRL_START = 1;
  localparam int CTRL_CLEAN = 2;

  localparam logic [3:0] TYPE_NULL   = 4'hF;
  localparam logic [3:0] CODE_DONE   = 4'd0;
  localparam logic [3:0] CODE_ABSENT = 4'd1;

  localparam int WORDS_PER_ENTRY_LOG2 = 3;
  localparam int MAC_W = 9;
endpackage

// File: rtl/sq_entry_ram.sv
module sq_entry_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [W-1:0]  host_wdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [W-1:0]  eng_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  // Single write port: the engine only writes while fetching is stopped,
  // and its nullify write wins over a simultaneous host write.
  always_ff @(posedge clk) begin
    if (eng_we)
      mem[eng_addr] <= eng_wdata;
    else if (host_we)
      mem[host_addr] <= host_wdata;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sq_credit.sv
module sq_credit #(
  parameter int MW     = 9,
  localparam int CNT_W = MW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] mac_field,
  input  logic          issue,
  input  logic          cpl,
  output logic          credit_ok
);
  logic [CNT_W-1:0] outstanding;
  logic [CNT_W-1:0] limit;

  assign limit     = {1'b0, mac_field} + CNT_W'(1);
  assign credit_ok = outstanding < limit;

  always_ff @(posedge clk) begin
    if (rst)
      outstanding <= '0;
    else if (issue && !cpl)
      outstanding <= outstanding + CNT_W'(1);
    else if (!issue && cpl && outstanding != '0)
      outstanding <= outstanding - CNT_W'(1);
  end

  // R9
  issue_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> outstanding < limit);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(outstanding) == '0 && !$past(issue)) |-> outstanding == '0);
endmodule

// File: rtl/sq_engine.sv
module sq_engine
  import sq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_en,
  input  logic [AW:0]   q_count,
  input  logic [AW-1:0] tail,
  input  logic [7:0]    cqid,
  input  logic          ctrl_stop,
  input  logic          ctrl_start,
  input  logic          ctrl_clean,
  input  logic [15:0]   nexus,
  input  logic          credit_ok,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data,
  output logic          issue,
  output logic [AW-1:0] head,
  output logic          stopped,
  output logic          cl_done,
  output logic [3:0]    cl_code,
  output logic          cmd_valid,
  output logic [W-1:0]  cmd_entry,
  output logic [7:0]    cmd_cqid
);
  eng_state_t   state;
  logic [AW-1:0] scan;
  logic          stop_req;
  logic [AW-1:0] head_nx, scan_nx;
  logic          is_null, hit, fetch_go;

  assign head_nx  = ({1'b0, head} + (AW+1)'(1) >= q_count) ? '0 : head + AW'(1);
  assign scan_nx  = ({1'b0, scan} + (AW+1)'(1) >= q_count) ? '0 : scan + AW'(1);
  assign is_null  = rd_data[W-1 -: 4] == TYPE_NULL;
  assign hit      = !is_null && rd_data[15:0] == nexus;
  assign fetch_go = q_en && !stop_req && head != tail && credit_ok;

  assign rd_addr = (state == ST_CL_RD || state == ST_CL_CMP) ? scan : head;
  assign issue   = state == ST_EVAL && !is_null && credit_ok;
  assign wr_en   = state == ST_CL_CMP && hit;
  assign wr_addr = scan;
  assign wr_data = {TYPE_NULL, rd_data[W-5:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_RUN;
      head      <= '0;
      scan      <= '0;
      stop_req  <= 1'b0;
      stopped   <= 1'b0;
      cl_done   <= 1'b0;
      cl_code   <= '0;
      cmd_valid <= 1'b0;
      cmd_entry <= '0;
      cmd_cqid  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (stop_req) begin
            state    <= ST_STOP;
            stopped  <= 1'b1;
            stop_req <= 1'b0;
          end else begin
            if (ctrl_stop) stop_req <= 1'b1;
            if (fetch_go) state <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (ctrl_stop) stop_req <= 1'b1;
          if (is_null) begin
            head  <= head_nx;
            state <= ST_RUN;
          end else if (credit_ok) begin
            cmd_valid <= 1'b1;
            cmd_entry <= rd_data;
            cmd_cqid  <= cqid;
            head      <= head_nx;
            state     <= ST_RUN;
          end
        end
        ST_STOP: begin
          if (ctrl_clean) begin
            scan    <= head;
            cl_done <= 1'b0;
            state   <= ST_CL_RD;
          end else if (ctrl_start) begin
            stopped <= 1'b0;
            state   <= ST_RUN;
          end
        end
        ST_CL_RD: begin
          if (scan == tail) begin
            cl_done <= 1'b1;
            cl_code <= CODE_ABSENT;
            state   <= ST_STOP;
          end else begin
            state <= ST_CL_CMP;
          end
        end
        ST_CL_CMP: begin
          if (hit) begin
            cl_done <= 1'b1;
            cl_code <= CODE_DONE;
            state   <= ST_STOP;
          end else begin
            scan  <= scan_nx;
            state <= ST_CL_RD;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R5
  quiet_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !cmd_valid);

  // R4
  null_never_issued_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_entry[W-1 -: 4] != TYPE_NULL);

  // R3
  head_steps_chk: assert property (@(posedge clk) disable iff (rst)
    head != $past(head) |-> (head == $past(head) + AW'(1) || head == '0));

  // R7
  clean_only_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cl_done) |-> stopped && $stable(head));
endmodule

// File: rtl/sq_fetch_ctrl.sv
module sq_fetch_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 32,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               mem_we,
  input  logic [AW-1:0]      mem_addr,
  input  logic [ENTRY_W-1:0] mem_wdata,
  input  logic               cpl,
  output logic               cmd_valid,
  output logic [ENTRY_W-1:0] cmd_entry,
  output logic [7:0]         cmd_cqid
);
  logic [31:0]   attr_q, cfg_q;
  logic [AW-1:0] tail_q;
  logic [15:0]   nexus_q;
  logic [16:0]   words;
  logic [16:0]   raw_count;
  logic [AW:0]   q_count;
  logic          ctrl_wr, c_stop, c_start, c_clean;

  logic [AW-1:0]      rd_addr, wr_addr, head;
  logic [ENTRY_W-1:0] rd_data, wr_data;
  logic wr_en, issue, credit_ok, stopped, cl_done;
  logic [3:0] cl_code;

  assign words     = {1'b0, attr_q[15:0]} + 17'd1;
  assign raw_count = words >> WORDS_PER_ENTRY_LOG2;
  assign q_count   = (raw_count > 17'(DEPTH)) ? (AW+1)'(DEPTH) : raw_count[AW:0];

  assign ctrl_wr = reg_we && reg_addr == A_CTRL;
  assign c_stop  = ctrl_wr && reg_wdata[CTRL_STOP];
  assign c_start = ctrl_wr && reg_wdata[CTRL_START];
  assign c_clean = ctrl_wr && reg_wdata[CTRL_CLEAN];

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q    <= '0;
      cfg_q     <= '0;
      tail_q    <= '0;
      nexus_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_we) begin
        unique case (reg_addr)
          A_ATTR:  attr_q  <= reg_wdata;
          A_CFG:   cfg_q   <= reg_wdata;
          A_TAIL:  tail_q  <= reg_wdata[AW-1:0];
          A_NEXUS: nexus_q <= reg_wdata[15:0];
          default: ;
        endcase
      end
      unique case (reg_addr)
        A_ATTR:   reg_rdata <= attr_q;
        A_CFG:    reg_rdata <= cfg_q;
        A_TAIL:   reg_rdata <= 32'(tail_q);
        A_HEAD:   reg_rdata <= 32'(head);
        A_NEXUS:  reg_rdata <= {16'h0, nexus_q};
        A_STATUS: reg_rdata <= {24'h0, cl_code, 2'b00, cl_done, stopped};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  sq_entry_ram #(.DEPTH(DEPTH), .W(ENTRY_W)) ram_i (
    .clk(clk), .host_we(mem_we), .host_addr(mem_addr), .host_wdata(mem_wdata),
    .eng_we(wr_en), .eng_addr(wr_addr), .eng_wdata(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  sq_credit #(.MW(MAC_W)) credit_i (
    .clk(clk), .rst(rst), .mac_field(cfg_q[16:8]), .issue(issue),
    .cpl(cpl), .credit_ok(credit_ok)
  );

  sq_engine #(.DEPTH(DEPTH), .W(ENTRY_W)) eng_i (
    .clk(clk), .rst(rst), .q_en(attr_q[31]), .q_count(q_count),
    .tail(tail_q), .cqid(attr_q[23:16]), .ctrl_stop(c_stop),
    .ctrl_start(c_start), .ctrl_clean(c_clean), .nexus(nexus_q),
    .credit_ok(credit_ok), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .issue(issue),
    .head(head), .stopped(stopped), .cl_done(cl_done), .cl_code(cl_code),
    .cmd_valid(cmd_valid), .cmd_entry(cmd_entry), .cmd_cqid(cmd_cqid)
  );

  // R8
  clean_ignored_running_chk: assert property (@(posedge clk) disable iff (rst)
    (c_clean && !stopped) |=> $stable(cl_done));

  // R1
  disabled_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    !attr_q[31] && !$past(attr_q[31]) |-> !cmd_valid);
endmodule

// File: tb/sq_fetch_ctrl_tb.sv
module sq_fetch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_we = 1'b0;
  logic [3:0]  mem_addr = '0;
  logic [31:0] mem_wdata = '0;
  logic        cpl = 1'b0;
  logic        cmd_valid;
  logic [31:0] cmd_entry;
  logic [7:0]  cmd_cqid;

  int errors = 0;
  int checks = 0;
  int ncap = 0;
  logic [7:0] cap_tag [64];
  logic [7:0] cap_cq  [64];

  always #10 clk = ~clk;

  sq_fetch_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cpl(cpl),
    .cmd_valid(cmd_valid), .cmd_entry(cmd_entry), .cmd_cqid(cmd_cqid)
  );

  always @(negedge clk) begin
    if (!rst && cmd_valid && ncap < 64) begin
      cap_tag[ncap] = cmd_entry[7:0];
      cap_cq[ncap]  = cmd_cqid;
      ncap++;
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] t, input logic [7:0] lun,
                                     input logic [7:0] tag);
    return {t, 12'h000, lun, tag};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic put(input int slot, input logic [31:0] e);
    @(negedge clk); mem_we = 1'b1; mem_addr = 4'(slot); mem_wdata = e;
    @(negedge clk); mem_we = 1'b0;
  endtask

  task automatic complete(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cpl = 1'b1;
      @(negedge clk); cpl = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R5 reset cmd_valid", 32'(cmd_valid), 0);
    rd(3'd6, v); chk("R11 reset status", v, 0);
    rd(3'd3, v); chk("R3 reset head", v, 0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    int base = ncap;
    wr(3'd1, 32'h0000_0700);
    wr(3'd0, 32'h0005_003F);
    for (int i = 0; i < 3; i++) put(i, mk(4'h1, 8'h02, 8'(10 + i)));
    wr(3'd2, 32'd3);
    rd(3'd2, v); chk("R3 tail readback", v, 3);
    idle(20);
    chk("R1 nothing issued while disabled", 32'(ncap - base), 0);
    wr(3'd0, 32'h8005_003F);
    idle(20);
    chk("R2 three issued", 32'(ncap - base), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R2 issue order", 32'(cap_tag[base + i]), 32'(10 + i));
      chk("R1 cqid", 32'(cap_cq[base + i]), 5);
    end
    rd(3'd3, v); chk("R2 head at tail", v, 3);
    complete(3);
  endtask

  task automatic t_skip();
    logic [31:0] v;
    int base = ncap;
    put(3, mk(4'hF, 8'h02, 8'd13));
    put(4, mk(4'h1, 8'h02, 8'd14));
    wr(3'd2, 32'd5);
    idle(20);
    chk("R4 null skipped", 32'(ncap - base), 1);
    chk("R4 next entry issued", 32'(cap_tag[base]), 14);
    rd(3'd3, v); chk("R4 head past null", v, 5);
    complete(1);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int base = ncap;
    put(5, mk(4'h1, 8'h01, 8'd20));
    put(6, mk(4'h1, 8'h01, 8'd21));
    put(7, mk(4'h1, 8'h01, 8'd22));
    put(0, mk(4'h1, 8'h01, 8'd23));
    wr(3'd2, 32'd1);
    idle(20);
    chk("R3 four issued across wrap", 32'(ncap - base), 4);
    for (int i = 0; i < 4; i++)
      chk("R3 wrap order", 32'(cap_tag[base + i]), 32'(20 + i));
    rd(3'd3, v); chk("R3 head wrapped", v, 1);
    complete(4);
  endtask

  task automatic t_credit();
    logic [31:0] v;
    int base = ncap;
    wr(3'd1, 32'h0000_0100);
    for (int i = 1; i <= 4; i++) put(i, mk(4'h1, 8'h00, 8'(29 + i)));
    wr(3'd2, 32'd5);
    idle(20);
    chk("R9 stalls at two", 32'(ncap - base), 2);
    rd(3'd3, v); chk("R9 head stalled", v, 3);
    complete(1); idle(10);
    chk("R10 one credit returned", 32'(ncap - base), 3);
    complete(2); idle(10);
    chk("R10 last entry issued", 32'(ncap - base), 4);
    complete(1);
    complete(3);
    put(5, mk(4'h1, 8'h00, 8'd34));
    put(6, mk(4'h1, 8'h00, 8'd35));
    put(7, mk(4'h1, 8'h00, 8'd36));
    wr(3'd2, 32'd0);
    idle(20);
    chk("R10 no underflow, limit holds", 32'(ncap - base), 6);
    complete(1); idle(10);
    chk("R9 final entry", 32'(ncap - base), 7);
    chk("R9 final tag", 32'(cap_tag[ncap - 1]), 36);
    complete(2);
    wr(3'd1, 32'h0000_0700);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(3'd5, 32'h0000_0123);
    wr(3'd4, 32'd4);
    idle(10);
    rd(3'd6, v); chk("R8 cleanup ignored while running", v, 0);
  endtask

  task automatic t_stop_start();
    logic [31:0] v;
    int base = ncap;
    wr(3'd4, 32'd1);
    idle(5);
    rd(3'd6, v); chk("R5 stopped bit", v & 32'h1, 1);
    put(0, mk(4'h1, 8'h00, 8'd40));
    put(1, mk(4'h1, 8'h00, 8'd41));
    wr(3'd2, 32'd2);
    idle(20);
    chk("R5 no fetch while stopped", 32'(ncap - base), 0);
    rd(3'd3, v); chk("R5 head held", v, 0);
    wr(3'd4, 32'd2);
    idle(20);
    rd(3'd6, v); chk("R6 stopped bit cleared", v & 32'h1, 0);
    chk("R6 resumed", 32'(ncap - base), 2);
    chk("R6 order", 32'(cap_tag[base + 1]), 41);
    complete(2);
  endtask

  task automatic t_cleanup();
    logic [31:0] v;
    int base = ncap;
    wr(3'd4, 32'd1);
    idle(5);
    for (int i = 0; i < 4; i++) put(2 + i, mk(4'h1, 8'h03, 8'(50 + i)));
    wr(3'd2, 32'd6);
    wr(3'd5, 32'h0000_0334);
    wr(3'd4, 32'd4);
    wr(3'd4, 32'd2);
    idle(20);
    rd(3'd6, v); chk("R7 found, start ignored (R8)", v, 32'h3);
    rd(3'd3, v); chk("R7 head unmoved", v, 2);
    wr(3'd5, 32'h0000_0363);
    wr(3'd4, 32'd4);
    idle(20);
    rd(3'd6, v); chk("R7 absent nexus", v, 32'h13);
    wr(3'd5, 32'h0000_0334);
    wr(3'd4, 32'd4);
    idle(20);
    rd(3'd6, v); chk("R7 nullified entry not found again", v, 32'h13);
    chk("R7 nothing issued during cleanup", 32'(ncap - base), 0);
    wr(3'd4, 32'd2);
    idle(20);
    chk("R7 three issued", 32'(ncap - base), 3);
    chk("R7 first", 32'(cap_tag[base]), 50);
    chk("R7 second", 32'(cap_tag[base + 1]), 51);
    chk("R7 nullified skipped", 32'(cap_tag[base + 2]), 53);
    rd(3'd3, v); chk("R7 head at tail", v, 6);
    complete(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_skip();
    t_wrap();
    t_credit();
    t_ignored();
    t_stop_start();
    t_cleanup();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule